// File: doc/BRIEF.md
# Block Write Protection Configuration Unit

This unit holds the write-protection settings of a serial memory with an 8K-byte array split into 16 equal blocks. It records a protected window, given as a starting block and a block count, which can be programmed once only. It also records which block is the relocatable high-endurance block. The bus front end captures the bytes of each command and hands them to this unit. The unit decodes configuration commands from those bytes and applies a change only when a complete command ends with STOP.

The write path asks the unit, for each byte address, whether that byte is protected. A protected byte is silently dropped. Because the query is made per address, a burst that crosses the window edge stores its unprotected bytes and loses the rest, and no error is raised. The unit also supplies the readback bytes for configuration read commands. Non-volatile storage is modelled as registers that take their factory defaults at reset.

Top module: `wpc_top`

## Requirements
- R1: After reset the starting block is 15, the count is 0, the high-endurance block is 15 and `locked` is 0.
- R2: The block of a query address is address bits 12:9. `qry_prot` is 1 when start <= block < start+count. The window is clipped at block 15 and never wraps to block 0.
- R3: When the count is 0, no address is protected, and this holds after a security write that programs a count of 0.
- R4: `cfg_hit` is 1 when bit 7 of the first address byte is set. The block number is taken from bits 4:1 of that byte. Bits 0, 5 and 6 have no effect.
- R5: A security write sets the start to the block number and the count to bits 3:0 of the configuration byte, and raises `locked`. A security write has configuration byte bit 7 = 1 and bit 6 = 0, and must be committed while unlocked.
- R6: Once `locked` is 1 it stays 1, and any later security write leaves the start and the count unchanged.
- R7: A high-endurance write sets the high-endurance block to the block number when the unit is unlocked. It has configuration byte bit 7 = 0 and bit 6 = 0. Once the unit is locked, this command has no effect.
- R8: `rb_first` is {1111, start} when configuration byte bit 7 is 1, and {1111, high-endurance block} when it is 0. `rb_second` is always {1111, count}.
- R9: A setting changes only on a cycle where `stop_pulse` and `cmd_full` are both 1. An aborted command, a read command (bit 6 = 1) and a command with first-byte bit 7 clear change nothing.
- R10: In a burst that straddles the window edge, `qry_prot` is 0 for the bytes just outside the window and 1 for the bytes just inside it. This holds at both the lower and the upper edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads factory defaults |
| addr_hi_byte | input | 8 | Captured first address byte of the current command |
| cfg_byte | input | 8 | Captured configuration byte |
| cmd_full | input | 1 | All command bytes were received and acknowledged |
| stop_pulse | input | 1 | One-cycle strobe on STOP |
| qry_addr | input | 13 | Byte address asked about by the write path |
| qry_prot | output | 1 | The queried byte is inside the protected window |
| cfg_hit | output | 1 | Current command is a configuration command |
| rb_first | output | 8 | First readback byte |
| rb_second | output | 8 | Second readback byte |
| locked | output | 1 | Security window has been programmed |

## Verification
The bench probes the last byte before each window edge and the first byte after it. An off-by-one in the bound would make a straddling burst lose or keep one block too many. It also programs a window that runs past block 15; a design that wraps the end would protect block 0. Aborted commands, read commands and non-configuration writes are each followed by readback. A design that commits without checking completion or the read bit would alter the settings that were just shown. After locking, both a second security write and a high-endurance relocation are attempted. A design that freezes only one of the two would show the change in readback.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_SEC_WR = 2'd1,
    CK_HE_WR  = 2'd2,
    CK_READ   = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/wpc_cmd_decode.sv
module wpc_cmd_decode
  import wpc_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr_hi_byte,
  input  logic [7:0]       cfg_byte,
  input  logic             cmd_full,
  input  logic             stop_pulse,
  input  logic             locked,
  output logic             cfg_hit,
  output cmd_kind_e        kind,
  output logic [BLK_W-1:0] blk_field,
  output logic [BLK_W-1:0] cnt_field,
  output logic             sec_commit,
  output logic             he_commit
);
  logic commit_ok;

  // R4: only bits 4:1 of the first byte carry the block
  assign cfg_hit   = addr_hi_byte[7];
  assign blk_field = addr_hi_byte[BLK_W:1];
  assign cnt_field = cfg_byte[BLK_W-1:0];

  always_comb begin
    if (!cfg_hit)         kind = CK_NONE;
    else if (cfg_byte[6]) kind = CK_READ;
    else if (cfg_byte[7]) kind = CK_SEC_WR;
    else                  kind = CK_HE_WR;
  end

  // R9: commit only on STOP ending a complete command
  assign commit_ok  = stop_pulse && cmd_full && !locked;
  assign sec_commit = commit_ok && (kind == CK_SEC_WR);
  assign he_commit  = commit_ok && (kind == CK_HE_WR);

  // R9
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sec_commit, he_commit}));

  // R9
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_commit || he_commit) |-> (stop_pulse && cmd_full && cfg_hit));

  // R6
  commit_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_commit |-> !locked);
endmodule

// File: rtl/wpc_store.sv
module wpc_store #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_commit,
  input  logic             he_commit,
  input  logic [BLK_W-1:0] blk_field,
  input  logic [BLK_W-1:0] cnt_field,
  output logic [BLK_W-1:0] win_start,
  output logic [BLK_W-1:0] win_count,
  output logic [BLK_W-1:0] he_blk,
  output logic             locked
);
  localparam logic [BLK_W-1:0] TOP_BLK = {BLK_W{1'b1}};

  // R1: factory defaults
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_start <= TOP_BLK;
      win_count <= '0;
      he_blk    <= TOP_BLK;
      locked    <= 1'b0;
    end else begin
      if (sec_commit) begin
        win_start <= blk_field;
        win_count <= cnt_field;
        locked    <= 1'b1;
      end
      if (he_commit) he_blk <= blk_field;
    end
  end

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R6 R7
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(win_start) && $stable(win_count) && $stable(he_blk)));
endmodule

// File: rtl/wpc_window.sv
module wpc_window #(
  parameter int ADDR_W = 13,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] qry_addr,
  input  logic [BLK_W-1:0]  win_start,
  input  logic [BLK_W-1:0]  win_count,
  output logic              prot
);
  logic [BLK_W-1:0] qry_blk;

  function automatic logic in_window(input logic [BLK_W-1:0] blk,
                                     input logic [BLK_W-1:0] st,
                                     input logic [BLK_W-1:0] cnt);
    logic [BLK_W:0] lim;
    lim = {1'b0, st} + {1'b0, cnt};
    return (cnt != '0) && (blk >= st) && ({1'b0, blk} < lim);
  endfunction

  // R2: block index from the top address bits
  assign qry_blk = qry_addr[ADDR_W-1 -: BLK_W];
  assign prot    = in_window(qry_blk, win_start, win_count);

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_count == '0) |-> !prot);

  // R2
  below_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_blk < win_start) |-> !prot);
endmodule

// File: rtl/wpc_top.sv
module wpc_top
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr_hi_byte,
  input  logic [7:0]        cfg_byte,
  input  logic              cmd_full,
  input  logic              stop_pulse,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_prot,
  output logic              cfg_hit,
  output logic [7:0]        rb_first,
  output logic [7:0]        rb_second,
  output logic              locked
);
  localparam int PAD_W = 8 - BLK_W;

  cmd_kind_e        kind;
  logic [BLK_W-1:0] blk_field, cnt_field;
  logic [BLK_W-1:0] win_start, win_count, he_blk;
  logic             sec_commit, he_commit;

  wpc_cmd_decode #(.BLK_W(BLK_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .addr_hi_byte(addr_hi_byte), .cfg_byte(cfg_byte),
    .cmd_full(cmd_full), .stop_pulse(stop_pulse), .locked(locked),
    .cfg_hit(cfg_hit), .kind(kind),
    .blk_field(blk_field), .cnt_field(cnt_field),
    .sec_commit(sec_commit), .he_commit(he_commit)
  );

  wpc_store #(.BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sec_commit(sec_commit), .he_commit(he_commit),
    .blk_field(blk_field), .cnt_field(cnt_field),
    .win_start(win_start), .win_count(win_count),
    .he_blk(he_blk), .locked(locked)
  );

  wpc_window #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .qry_addr(qry_addr), .win_start(win_start), .win_count(win_count),
    .prot(qry_prot)
  );

  // R8: readback with the upper bits forced high
  assign rb_first  = {{PAD_W{1'b1}}, (cfg_byte[7] ? win_start : he_blk)};
  assign rb_second = {{PAD_W{1'b1}}, win_count};

  // R9
  read_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_READ) |-> !(sec_commit || he_commit));
endmodule

// File: tb/wpc_top_test.sv
module wpc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr_hi_byte = 8'h00;
  logic [7:0]  cfg_byte = 8'h00;
  logic        cmd_full = 1'b0;
  logic        stop_pulse = 1'b0;
  logic [12:0] qry_addr = '0;
  logic        qry_prot, cfg_hit, locked;
  logic [7:0]  rb_first, rb_second;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wpc_top uut (
    .clk(clk), .rst_n(rst_n), .addr_hi_byte(addr_hi_byte), .cfg_byte(cfg_byte),
    .cmd_full(cmd_full), .stop_pulse(stop_pulse), .qry_addr(qry_addr),
    .qry_prot(qry_prot), .cfg_hit(cfg_hit), .rb_first(rb_first),
    .rb_second(rb_second), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cmd_full = 0; stop_pulse = 0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive a command, pulse STOP for one edge, settle
  task automatic send_cmd(input logic [7:0] a, input logic [7:0] c, input logic full);
    @(negedge clk);
    addr_hi_byte = a; cfg_byte = c; cmd_full = full; stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0; cmd_full = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_sec(input string req, input int st, input int cnt);
    cfg_byte = 8'hC0; #1;
    chk(req, rb_first, 8'hF0 | st);
    chk(req, rb_second, 8'hF0 | cnt);
  endtask

  task automatic read_he(input string req, input int he);
    cfg_byte = 8'h40; #1;
    chk(req, rb_first, 8'hF0 | he);
  endtask

  task automatic probe(input string req, input int a, input bit exp);
    qry_addr = a[12:0]; #1;
    chk(req, qry_prot, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 locked", locked, 0);
    read_sec("R1", 15, 0);
    read_he("R1", 15);
    for (int b = 0; b < 16; b++) probe("R3 default", b * 512, 0);
  endtask

  task automatic t_he_relocate();
    addr_hi_byte = 8'hE7; #1;
    chk("R4 cfg_hit", cfg_hit, 1);
    addr_hi_byte = 8'h66; #1;
    chk("R4 cfg_hit clear", cfg_hit, 0);
    send_cmd(8'hE7, 8'h00, 1'b1);   // block 3, bits 0,5,6 set
    read_he("R7 R4 relocate", 3);
    chk("R7 not locked", locked, 0);
  endtask

  task automatic t_no_commit();
    send_cmd(8'h8A, 8'h83, 1'b0);   // aborted
    chk("R9 abort", locked, 0);
    read_sec("R9 abort", 15, 0);
    send_cmd(8'h8A, 8'hC3, 1'b1);   // read command
    read_sec("R9 read", 15, 0);
    send_cmd(8'h0A, 8'h83, 1'b1);   // not a config command
    read_sec("R9 normal", 15, 0);
    read_he("R9 he kept", 3);
    chk("R9 lock", locked, 0);
  endtask

  task automatic t_sec_write();
    send_cmd(8'h6A | 8'h80, 8'hB3, 1'b1); // start 5, count 3, ignored bits set
    chk("R5 locked", locked, 1);
    read_sec("R5", 5, 3);
    probe("R10 below", 2559, 0);
    probe("R10 first in", 2560, 1);
    probe("R2 mid", 3000, 1);
    probe("R10 last in", 4095, 1);
    probe("R10 above", 4096, 0);
  endtask

  task automatic t_locked();
    send_cmd(8'h80, 8'h8F, 1'b1);
    read_sec("R6 second sec", 5, 3);
    chk("R6 lock", locked, 1);
    send_cmd(8'h92, 8'h00, 1'b1);   // try HE to block 9
    read_he("R7 locked he", 3);
  endtask

  task automatic t_clip();
    do_reset();
    send_cmd(8'h98, 8'h8A, 1'b1);   // start 12, count 10
    read_sec("R2 clip", 12, 10);
    probe("R2 clip top", 8191, 1);
    probe("R2 clip 12", 6144, 1);
    probe("R2 clip 11", 6143, 0);
    probe("R2 no wrap", 0, 0);
    probe("R2 no wrap 1", 600, 0);
  endtask

  task automatic t_zero_count();
    do_reset();
    send_cmd(8'h84, 8'h80, 1'b1);   // start 2, count 0
    chk("R3 locked", locked, 1);
    for (int b = 0; b < 16; b++) probe("R3 zero", b * 512 + 7, 0);
  endtask

  initial begin
    t_reset();
    t_he_relocate();
    t_no_commit();
    t_sec_write();
    t_locked();
    t_clip();
    t_zero_count();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule